// File: doc/BRIEF.md
# Multicycle Processor Core with Step-Sequenced Control

This block is a 32-bit processor that runs a small integer subset: word load and store, five register-to-register arithmetic and logic operations, branch-on-equal and an unconditional jump. Each instruction is spread over several clock cycles. One ALU is shared between incrementing the program counter, computing branch targets, forming memory addresses and producing results. One word-addressed memory holds both the program and its data. Values are carried from one cycle to the next in five internal registers: the fetched instruction, the word read from memory, two operand registers and the ALU result register.

The control is a Moore state machine. Its outputs depend only on the current step and drive every multiplexer select and every write enable. The common entry steps are fetch and then decode. After that, each instruction class takes its own path, so instructions last 3, 4 or 5 cycles. The memory array sits inside the block and is filled by the environment while reset is held. Register-file writes, memory writes, the program counter and the first cycle of each instruction are all visible on output ports.

Top module: `mc_core`

## Requirements
- R1: While reset is asserted, `pc_o` is 0, `fetch_o` is 1, and `rf_we_o` and `dmem_we_o` are 0. Execution starts with a fetch from byte address 0.
- R2: Instructions are fetched from the same word array that loads read and stores write. The word index is byte address bits [9:2] when the depth is 256 words. A load can therefore read an instruction word.
- R3: In the fetch cycle (`fetch_o`=1), the instruction at `pc_o` is captured and PC becomes PC+4. Decode always follows fetch.
- R4: Register format is opcode 0 (bits [31:26]), with rs at [25:21], rt at [20:16], rd at [15:11] and funct at [5:0].
  - The funct codes are: 0x20 add, 0x22 subtract (rs−rt), 0x24 and, 0x25 or, 0x2A signed set-less-than (1 or 0).
  - The result is written to rd.
  - The instruction takes 4 cycles.
- R5: Load (opcode 0x23) writes the memory word at rs+sign-extended imm[15:0] into rt and takes 5 cycles.
- R6: Store (opcode 0x2B) writes rt to the memory word at rs+sign-extended imm and takes 4 cycles. The write is visible on `dmem_*` with the byte address.
- R7: Branch-on-equal (opcode 0x04) takes 3 cycles.
  - If rs equals rt, PC becomes PC+4+(sign-extended imm<<2), and the offset may be negative.
  - Otherwise PC stays at PC+4.
- R8: Jump (opcode 0x02) sets PC to {upper 4 bits of PC+4, imm[25:0], 2'b00} and takes 3 cycles.
- R9: Register 0 always reads as zero. A write aimed at it appears on the write port but does not change it.
- R10: Any other opcode returns to fetch after decode (2 cycles) and writes no state other than PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pc_o | output | 32 | Current program counter |
| fetch_o | output | 1 | High in the first cycle of each instruction |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| dmem_we_o | output | 1 | Memory write strobe |
| dmem_addr_o | output | 32 | Memory write byte address |
| dmem_wdata_o | output | 32 | Memory write data |

## Verification
The hardest behaviour to reach from the ports is the path where a register value that cannot be seen directly has to prove its worth. Examples are a write aimed at register 0 that must leave no trace, and a branch that compares two registers filled several instructions earlier. The program used as stimulus handles both. It first attempts the register-0 write. It then stores register 0 to memory so the value shows on the write port. It also stores a sum, reloads it into another register, and uses that register in a taken branch. A backward branch onto itself closes the program. This confirms the negative offset and the 3-cycle length on every fetch.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_MEMADR, ST_MEMRD, ST_LOADWB,
    ST_MEMWR, ST_EXEC, ST_REGWB, ST_BRANCH, ST_JUMP
  } step_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000, ALU_OR = 3'b001, ALU_ADD = 3'b010,
    ALU_SUB = 3'b110, ALU_SLT = 3'b111
  } alu_sel_e;

  typedef enum logic [1:0] { AOP_ADD, AOP_SUB, AOP_FUNCT } aluop_e;
  typedef enum logic [1:0] { SRCB_REG, SRCB_FOUR, SRCB_IMM, SRCB_IMMSH } srcb_e;
  typedef enum logic [1:0] { PCS_ALU, PCS_HELD, PCS_JUMP } pcsrc_e;

  typedef struct packed {
    logic   addr_from_out;
    logic   mem_we;
    logic   ir_we;
    logic   mdr_we;
    logic   ab_we;
    logic   out_we;
    logic   pc_we;
    logic   pc_we_zero;
    logic   rf_we;
    logic   dst_rd;
    logic   wb_from_mdr;
    logic   srca_reg;
    srcb_e  srcb;
    aluop_e aluop;
    pcsrc_e pcsrc;
  } ctl_t;

endpackage

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  opcode,
  output step_e       step,
  output ctl_t        ctl
);

  step_e step_q, step_d;

  always_comb begin
    step_d = ST_FETCH;
    unique case (step_q)
      ST_FETCH:  step_d = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OPC_RTYPE)                            step_d = ST_EXEC;
        else if (opcode == OPC_LOAD || opcode == OPC_STORE) step_d = ST_MEMADR;
        else if (opcode == OPC_BEQ)                         step_d = ST_BRANCH;
        else if (opcode == OPC_JUMP)                        step_d = ST_JUMP;
        else                                                step_d = ST_FETCH;
      end
      ST_MEMADR: step_d = (opcode == OPC_LOAD) ? ST_MEMRD : ST_MEMWR;
      ST_MEMRD:  step_d = ST_LOADWB;
      ST_EXEC:   step_d = ST_REGWB;
      default:   step_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_FETCH;
    else        step_q <= step_d;
  end

  // Moore outputs: a function of the current step only
  always_comb begin
    ctl = '0;
    unique case (step_q)
      ST_FETCH: begin
        ctl.ir_we = 1'b1;
        ctl.pc_we = 1'b1;
        ctl.srcb  = SRCB_FOUR;
      end
      ST_DECODE: begin
        ctl.ab_we  = 1'b1;
        ctl.out_we = 1'b1;
        ctl.srcb   = SRCB_IMMSH;
      end
      ST_MEMADR: begin
        ctl.srca_reg = 1'b1;
        ctl.srcb     = SRCB_IMM;
        ctl.out_we   = 1'b1;
      end
      ST_MEMRD: begin
        ctl.addr_from_out = 1'b1;
        ctl.mdr_we        = 1'b1;
      end
      ST_LOADWB: begin
        ctl.rf_we       = 1'b1;
        ctl.wb_from_mdr = 1'b1;
      end
      ST_MEMWR: begin
        ctl.addr_from_out = 1'b1;
        ctl.mem_we        = 1'b1;
      end
      ST_EXEC: begin
        ctl.srca_reg = 1'b1;
        ctl.aluop    = AOP_FUNCT;
        ctl.out_we   = 1'b1;
      end
      ST_REGWB: begin
        ctl.rf_we  = 1'b1;
        ctl.dst_rd = 1'b1;
      end
      ST_BRANCH: begin
        ctl.srca_reg   = 1'b1;
        ctl.aluop      = AOP_SUB;
        ctl.pc_we_zero = 1'b1;
        ctl.pcsrc      = PCS_HELD;
      end
      ST_JUMP: begin
        ctl.pc_we = 1'b1;
        ctl.pcsrc = PCS_JUMP;
      end
      default: ctl = '0;
    endcase
  end

  assign step = step_q;

  // R3
  fetch_then_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_FETCH) |=> (step_q == ST_DECODE));

  // R4 R6 R7 R8: final step of every path hands back to fetch
  last_step_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_REGWB || step_q == ST_LOADWB || step_q == ST_MEMWR ||
     step_q == ST_BRANCH || step_q == ST_JUMP) |=> (step_q == ST_FETCH));

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  aluop_e       aluop,
  input  logic [5:0]   funct,
  output logic [W-1:0] res,
  output logic         zero
);

  alu_sel_e sel;

  always_comb begin
    sel = ALU_ADD;
    unique case (aluop)
      AOP_SUB: sel = ALU_SUB;
      AOP_FUNCT: begin
        unique case (funct)
          FN_SUB:  sel = ALU_SUB;
          FN_AND:  sel = ALU_AND;
          FN_OR:   sel = ALU_OR;
          FN_SLT:  sel = ALU_SLT;
          default: sel = ALU_ADD;
        endcase
      end
      default: sel = ALU_ADD;
    endcase
  end

  always_comb begin
    unique case (sel)
      ALU_AND: res = a & b;
      ALU_OR:  res = a | b;
      ALU_SUB: res = a - b;
      ALU_SLT: res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: res = a + b;
    endcase
  end

  assign zero = (res == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] ra1,
  input  logic [IW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [IW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs_q [1:NREG-1];

  generate
    for (genvar g = 1; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        regs_q[g] <= '0;
        else if (we && wa == IW'(g))       regs_q[g] <= wd;
      end
    end
  endgenerate

  assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];

endmodule

// File: rtl/mc_mem.sv
module mc_mem #(
  parameter int W     = 32,
  parameter int WORDS = 256,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic         clk,
  input  logic [W-1:0] addr,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] rd
);

  logic [W-1:0] words_q [WORDS];
  logic [AW-1:0] idx;

  assign idx = addr[AW+1:2];
  assign rd  = words_q[idx];

  always_ff @(posedge clk) begin
    if (we) words_q[idx] <= wd;
  end

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 256,
  parameter int NREG      = 32,
  localparam int RIW      = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DATA_W-1:0] pc_o,
  output logic              fetch_o,
  output logic              rf_we_o,
  output logic [RIW-1:0]    rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              dmem_we_o,
  output logic [DATA_W-1:0] dmem_addr_o,
  output logic [DATA_W-1:0] dmem_wdata_o
);

  step_e step;
  ctl_t  ctl;

  logic [DATA_W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, out_q;
  logic [DATA_W-1:0] mem_addr, mem_rd, rf_rd1, rf_rd2;
  logic [DATA_W-1:0] alu_a, alu_b, alu_res, imm_sx, pc_d, rf_wd;
  logic [RIW-1:0]    rf_wa;
  logic              alu_zero, pc_load;

  mc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(ir_q[31:26]), .step(step), .ctl(ctl)
  );

  mc_mem #(.W(DATA_W), .WORDS(MEM_WORDS)) u_mem (
    .clk(clk), .addr(mem_addr), .we(ctl.mem_we), .wd(b_q), .rd(mem_rd)
  );

  mc_regfile #(.W(DATA_W), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra1(ir_q[21+:RIW]), .ra2(ir_q[16+:RIW]), .rd1(rf_rd1), .rd2(rf_rd2),
    .we(ctl.rf_we), .wa(rf_wa), .wd(rf_wd)
  );

  mc_alu #(.W(DATA_W)) u_alu (
    .a(alu_a), .b(alu_b), .aluop(ctl.aluop), .funct(ir_q[5:0]),
    .res(alu_res), .zero(alu_zero)
  );

  assign mem_addr = ctl.addr_from_out ? out_q : pc_q;
  assign imm_sx   = {{(DATA_W-16){ir_q[15]}}, ir_q[15:0]};
  assign alu_a    = ctl.srca_reg ? a_q : pc_q;

  always_comb begin
    unique case (ctl.srcb)
      SRCB_FOUR:  alu_b = DATA_W'(4);
      SRCB_IMM:   alu_b = imm_sx;
      SRCB_IMMSH: alu_b = {imm_sx[DATA_W-3:0], 2'b00};
      default:    alu_b = b_q;
    endcase
  end

  always_comb begin
    unique case (ctl.pcsrc)
      PCS_HELD: pc_d = out_q;
      PCS_JUMP: pc_d = {pc_q[DATA_W-1:28], ir_q[25:0], 2'b00};
      default:  pc_d = alu_res;
    endcase
  end

  assign pc_load = ctl.pc_we | (ctl.pc_we_zero & alu_zero);
  assign rf_wa   = ctl.dst_rd ? ir_q[11+:RIW] : ir_q[16+:RIW];
  assign rf_wd   = ctl.wb_from_mdr ? mdr_q : out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      out_q <= '0;
    end else begin
      if (pc_load)    pc_q  <= pc_d;
      if (ctl.ir_we)  ir_q  <= mem_rd;
      if (ctl.mdr_we) mdr_q <= mem_rd;
      if (ctl.ab_we) begin
        a_q <= rf_rd1;
        b_q <= rf_rd2;
      end
      if (ctl.out_we) out_q <= alu_res;
    end
  end

  assign pc_o         = pc_q;
  assign fetch_o      = (step == ST_FETCH);
  assign rf_we_o      = ctl.rf_we;
  assign rf_waddr_o   = rf_wa;
  assign rf_wdata_o   = rf_wd;
  assign dmem_we_o    = ctl.mem_we;
  assign dmem_addr_o  = out_q;
  assign dmem_wdata_o = b_q;

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_DECODE) |-> (pc_q == $past(pc_q) + DATA_W'(4)));

  // R3
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step != ST_FETCH) |=> $stable(ir_q));

  // R7
  beq_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step) == ST_BRANCH && $past(alu_zero)) |-> (pc_q == $past(out_q)));

  // R7
  beq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step) == ST_BRANCH && !$past(alu_zero)) |-> (pc_q == $past(pc_q)));

  // R8
  jump_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step) == ST_JUMP) |->
      (pc_q[1:0] == 2'b00 && pc_q[DATA_W-1:28] == $past(pc_q[DATA_W-1:28])));

endmodule

// File: tb/mc_core_bench.sv
module mc_core_bench;

  localparam int K_FETCH = 0;
  localparam int K_RF    = 1;
  localparam int K_MEM   = 2;

  typedef struct {
    int          kind;
    logic [31:0] a;
    logic [31:0] d;
    int          req;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pc_o, rf_wdata_o, dmem_addr_o, dmem_wdata_o;
  logic [4:0]  rf_waddr_o;
  logic        fetch_o, rf_we_o, dmem_we_o;

  int  total = 0;
  int  bad   = 0;
  int  cyc   = 0;
  int  last_fetch = 0;
  bit  seen_fetch = 0;
  bit  done = 0;
  ev_t exp_q[$];

  always #5 clk = ~clk;

  mc_core u_mc_core (
    .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .fetch_o(fetch_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dmem_we_o(dmem_we_o), .dmem_addr_o(dmem_addr_o), .dmem_wdata_o(dmem_wdata_o)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] idx);
    return {6'h02, idx};
  endfunction

  task automatic push(int kind, logic [31:0] a, logic [31:0] d, int req);
    ev_t e;
    e.kind = kind; e.a = a; e.d = d; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic check(string what, int req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic observe(int kind, logic [31:0] a, logic [31:0] d);
    ev_t e;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    total++;
    if (e.kind != kind || e.a !== a || e.d !== d) begin
      bad++;
      $display("FAIL R%0d event: actual kind=%0d a=%h d=%h expected kind=%0d a=%h d=%h",
               e.req, kind, a, d, e.kind, e.a, e.d);
    end
    if (exp_q.size() == 0) done = 1;
  endtask

  // monitor: samples away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      cyc++;
      if (fetch_o) begin
        observe(K_FETCH, pc_o, seen_fetch ? 32'(cyc - last_fetch) : 32'd0);
        last_fetch = cyc;
        seen_fetch = 1;
      end
      if (rf_we_o)   observe(K_RF, {27'd0, rf_waddr_o}, rf_wdata_o);
      if (dmem_we_o) observe(K_MEM, dmem_addr_o, dmem_wdata_o);
    end
  end

  initial begin
    logic [31:0] prog [22];
    rst_n = 1'b0;

    prog[0]  = enc_i(6'h23, 0, 1, 16'h0100);   // lw  $1
    prog[1]  = enc_i(6'h23, 0, 2, 16'h0104);   // lw  $2
    prog[2]  = enc_i(6'h23, 0, 3, 16'h0108);   // lw  $3
    prog[3]  = enc_r(1, 2, 4, 6'h20);          // add $4=$1+$2
    prog[4]  = enc_r(2, 1, 5, 6'h22);          // sub $5=$2-$1
    prog[5]  = enc_r(1, 2, 6, 6'h24);          // and
    prog[6]  = enc_r(1, 2, 7, 6'h25);          // or
    prog[7]  = enc_r(3, 1, 8, 6'h2A);          // slt -2<5
    prog[8]  = enc_r(1, 3, 9, 6'h2A);          // slt 5<-2
    prog[9]  = enc_r(1, 1, 0, 6'h20);          // add into $0
    prog[10] = enc_i(6'h2B, 0, 0, 16'h0110);   // sw $0
    prog[11] = enc_i(6'h2B, 0, 4, 16'h0114);   // sw $4
    prog[12] = enc_i(6'h23, 0, 10, 16'h0114);  // lw $10
    prog[13] = enc_i(6'h04, 1, 2, 16'h0005);   // beq not taken
    prog[14] = enc_i(6'h04, 4, 10, 16'h0002);  // beq taken -> word 17
    prog[15] = enc_i(6'h2B, 0, 1, 16'h0118);   // skipped
    prog[16] = enc_i(6'h2B, 0, 1, 16'h0118);   // skipped
    prog[17] = 32'hFC00_0000;                  // undefined opcode
    prog[18] = enc_j(26'd20);                  // j word 20
    prog[19] = enc_i(6'h2B, 0, 1, 16'h0118);   // skipped
    prog[20] = enc_i(6'h23, 0, 11, 16'h0000);  // lw instruction word 0
    prog[21] = enc_i(6'h04, 0, 0, 16'hFFFF);   // beq to itself

    for (int i = 0; i < 256; i++) u_mc_core.u_mem.words_q[i] = 32'd0;
    for (int i = 0; i < 22; i++)  u_mc_core.u_mem.words_q[i] = prog[i];
    u_mc_core.u_mem.words_q[64] = 32'd5;
    u_mc_core.u_mem.words_q[65] = 32'd3;
    u_mc_core.u_mem.words_q[66] = 32'hFFFF_FFFE;
    u_mc_core.u_mem.words_q[67] = 32'h0000_0F0F;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("reset pc", 1, pc_o, 32'd0);
    check("reset fetch", 1, {31'd0, fetch_o}, 32'd1);
    check("reset rf_we", 1, {31'd0, rf_we_o}, 32'd0);
    check("reset mem_we", 1, {31'd0, dmem_we_o}, 32'd0);

    // driver: expected trace (fetch events carry pc and previous length)
    push(K_FETCH, 32'h00, 0, 1);  push(K_RF, 1, 32'd5, 5);          // R1 R5
    push(K_FETCH, 32'h04, 5, 5);  push(K_RF, 2, 32'd3, 5);          // R5 length 5
    push(K_FETCH, 32'h08, 5, 5);  push(K_RF, 3, 32'hFFFF_FFFE, 5);
    push(K_FETCH, 32'h0C, 5, 3);  push(K_RF, 4, 32'd8, 4);          // R3 R4 add
    push(K_FETCH, 32'h10, 4, 4);  push(K_RF, 5, 32'hFFFF_FFFE, 4);  // R4 sub
    push(K_FETCH, 32'h14, 4, 4);  push(K_RF, 6, 32'd1, 4);          // and
    push(K_FETCH, 32'h18, 4, 4);  push(K_RF, 7, 32'd7, 4);          // or
    push(K_FETCH, 32'h1C, 4, 4);  push(K_RF, 8, 32'd1, 4);          // slt signed
    push(K_FETCH, 32'h20, 4, 4);  push(K_RF, 9, 32'd0, 4);
    push(K_FETCH, 32'h24, 4, 4);  push(K_RF, 0, 32'd10, 9);         // R9 write to $0 shown
    push(K_FETCH, 32'h28, 4, 4);  push(K_MEM, 32'h110, 32'd0, 9);   // R9 $0 still zero
    push(K_FETCH, 32'h2C, 4, 6);  push(K_MEM, 32'h114, 32'd8, 6);   // R6 store
    push(K_FETCH, 32'h30, 4, 6);  push(K_RF, 10, 32'd8, 2);         // R2 readback
    push(K_FETCH, 32'h34, 5, 5);                                    // beq not taken next
    push(K_FETCH, 32'h38, 3, 7);                                    // R7 fall through
    push(K_FETCH, 32'h44, 3, 7);                                    // R7 taken
    push(K_FETCH, 32'h48, 2, 10);                                   // R10 2 cycles
    push(K_FETCH, 32'h50, 3, 8);                                    // R8 jump
    push(K_RF, 11, prog[0], 2);                                     // R2 instruction as data
    push(K_FETCH, 32'h54, 5, 7);
    push(K_FETCH, 32'h54, 3, 7);                                    // R7 backward offset
    push(K_FETCH, 32'h54, 3, 7);

    rst_n = 1'b1;

    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual=%0d expected=0 pending events", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule